// File: doc/BRIEF.md
# Self-Timing Bi-Phase Infrared Frame Decoder

This block takes the demodulated output of an infrared receiver (line high when no carrier, low while carrier is present) and recovers a 12-bit bi-phase frame: a toggle flag, a 5-bit system address and a 6-bit command. Time is measured in ticks of an external timebase, nominally about 64 us each. Before it looks for a frame, the decoder waits until the line has been quiet for a while. It then measures the low half of the first start bit and uses that width to set every later sampling and timeout threshold. A transmitter whose bit period differs somewhat from nominal is therefore still decoded.

Each data bit is sampled three quarters of a bit period after the previous mid-bit transition. The decoder then waits for that bit's own mid-bit transition and restarts its phase timer on it, so timing error does not build up across the frame. A good frame ends with a one-clock valid pulse and new field values. Any timing violation ends the attempt with a one-clock fault pulse, and both field outputs are forced to all ones. After either outcome the decoder begins a fresh attempt on its own.

Top module: `ir_manchester_rx`

## Requirements
- R1: A start bit is accepted only after the line has been high for IDLE_TICKS (default 55) consecutive ticks since the current attempt began. Any low level, however short, restarts that count.
- R2: If the decoder has not seen the idle period followed by a start-bit low within TIMEOUT_TICKS (default 2048) ticks of the start of an attempt, the attempt ends with a fault.
- R3: The low width of the first start bit, counted in ticks, is taken as the half-bit time H. If that width reaches HALF_LIMIT (default 17) ticks, the attempt ends with a fault. A width of 15 ticks is accepted.
- R4: Two thresholds are derived from H: S = H + floor(H/2) and E = 2H + floor(H/2). If the high phase that follows the first start bit lasts S ticks or more, the attempt ends with a fault. The falling edge that ends that high phase restarts the phase timer.
- R5: Each of the 12 frame bits is sampled S ticks after the previous mid-bit edge (high = 1, low = 0). The first bit received is the toggle flag. The next five bits form the system address, most significant bit first. The last six bits form the command, most significant bit first.
- R6: After a 0 has been sampled, the decoder waits for a rising edge; after a 1, it waits for a falling edge. If that edge has not arrived E ticks after the previous mid-bit edge, the attempt ends with a fault.
- R7: When the twelfth bit's mid-bit edge arrives, frame_valid is high for exactly one clock. In that same clock, toggle, sys_addr and command show the decoded fields.
- R8: A fault gives a one-clock fault pulse. In that same clock, sys_addr is 5'h1F and command is 6'h3F. The toggle output keeps its previous value, and frame_valid stays low.
- R9: The bit period is learned per frame: frames with half-bit times from 8 to 15 ticks all decode correctly.
- R10: After reset, sys_addr, command and toggle are zero, and frame_valid and fault are low.
- R11: After a valid frame or a fault, a new attempt begins at once, so that the next well-formed frame is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase pulse, one per time unit |
| ir_in | input | 1 | Raw demodulated infrared line, high when idle |
| sys_addr | output | SYS_W | Last decoded system address, all ones after a fault |
| command | output | CMD_W | Last decoded command, all ones after a fault |
| toggle | output | 1 | Toggle flag of the last good frame |
| frame_valid | output | 1 | One-clock pulse when a frame has been decoded |
| fault | output | 1 | One-clock pulse when a decode attempt fails |

## Verification
A wrong learned half-bit value or a wrong threshold shifts every sample point. The damage shows at the end of the same frame, either as wrong field bits or as a fault pulse where a valid pulse was due. A phase timer that is not restarted on a mid-bit edge lets error build up, so a frame with a long or short bit period fails within a few bits. A broken attempt counter shows as a fault that comes too early or not at all, about 2048 ticks after the last outcome. The stimulus therefore includes bit periods at both ends of the supported range and idle holds on either side of that limit.

// File: rtl/irdec_pkg.sv
package irdec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_START,
    ST_MEASURE,
    ST_START2,
    ST_SAMPLE,
    ST_EDGE
  } dec_state_t;

  // Sample point: three quarters of a bit period from the previous mid-bit edge.
  function automatic int thr_sample(input int half);
    return half + (half >> 1);
  endfunction

  // Edge deadline: five quarters of a bit period from the previous mid-bit edge.
  function automatic int thr_edge(input int half);
    return (2 * half) + (half >> 1);
  endfunction

endpackage

// File: rtl/ir_sync.sv
module ir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/ir_tick_count.sv
module ir_tick_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (clr)                 count <= '0;
    else if (tick && count != '1) count <= count + 1'b1;
  end
endmodule

// File: rtl/ir_frame_fsm.sv
module ir_frame_fsm
  import irdec_pkg::*;
#(
  parameter int NBITS         = 12,
  parameter int IDLE_TICKS    = 55,
  parameter int HALF_LIMIT    = 17,
  parameter int TIMEOUT_TICKS = 2048,
  localparam int IW   = $clog2(IDLE_TICKS + 1),
  localparam int AW   = $clog2(TIMEOUT_TICKS + 1),
  localparam int PW   = $clog2(3 * HALF_LIMIT + 1),
  localparam int HW   = $clog2(HALF_LIMIT + 1),
  localparam int BC_W = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_s,
  input  logic [IW-1:0]    idle_cnt,
  input  logic [AW-1:0]    attempt_cnt,
  input  logic [PW-1:0]    phase_cnt,
  output logic             idle_clr,
  output logic             attempt_clr,
  output logic             phase_clr,
  output logic             ev_done,
  output logic             ev_fault,
  output logic [NBITS-1:0] frame_word
);
  dec_state_t        state_q, state_d;
  logic [HW-1:0]     half_q;
  logic [NBITS-1:0]  shift_q;
  logic [BC_W-1:0]   bits_left_q;
  logic              last_bit_q;

  // Named internal events
  logic ev_start_seen, ev_half_latched, ev_st2_edge, ev_bit_sampled, ev_mid_edge;
  logic attempt_expired, idle_met, hunting;
  logic [PW-1:0] ref_sample, ref_edge;

  assign ref_sample      = PW'(thr_sample(int'(half_q)));
  assign ref_edge        = PW'(thr_edge(int'(half_q)));
  assign attempt_expired = attempt_cnt >= AW'(TIMEOUT_TICKS);
  assign idle_met        = line_s && (idle_cnt >= IW'(IDLE_TICKS));
  assign hunting         = (state_q == ST_IDLE) || (state_q == ST_WAIT_START);

  always_comb begin
    state_d         = state_q;
    phase_clr       = 1'b0;
    ev_start_seen   = 1'b0;
    ev_half_latched = 1'b0;
    ev_st2_edge     = 1'b0;
    ev_bit_sampled  = 1'b0;
    ev_mid_edge     = 1'b0;
    ev_done         = 1'b0;
    ev_fault        = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (attempt_expired)  ev_fault = 1'b1;
        else if (idle_met)    state_d  = ST_WAIT_START;
      end
      ST_WAIT_START: begin
        if (attempt_expired) ev_fault = 1'b1;
        else if (!line_s) begin
          ev_start_seen = 1'b1;
          phase_clr     = 1'b1;
          state_d       = ST_MEASURE;
        end
      end
      ST_MEASURE: begin
        if (phase_cnt >= PW'(HALF_LIMIT)) ev_fault = 1'b1;
        else if (line_s) begin
          ev_half_latched = 1'b1;
          phase_clr       = 1'b1;
          state_d         = ST_START2;
        end
      end
      ST_START2: begin
        if (phase_cnt >= ref_sample) ev_fault = 1'b1;
        else if (!line_s) begin
          ev_st2_edge = 1'b1;
          phase_clr   = 1'b1;
          state_d     = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        if (phase_cnt >= ref_sample) begin
          ev_bit_sampled = 1'b1;
          state_d        = ST_EDGE;
        end
      end
      ST_EDGE: begin
        if (phase_cnt >= ref_edge) ev_fault = 1'b1;
        else if (line_s != last_bit_q) begin
          ev_mid_edge = 1'b1;
          phase_clr   = 1'b1;
          if (bits_left_q == BC_W'(1)) begin
            ev_done = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_SAMPLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (ev_fault) state_d = ST_IDLE;
  end

  assign idle_clr    = !line_s || (state_q != ST_IDLE) || ev_fault;
  assign attempt_clr = ev_fault || ev_done || !hunting;
  assign frame_word  = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      half_q      <= '0;
      shift_q     <= '0;
      bits_left_q <= '0;
      last_bit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_half_latched) half_q <= HW'(phase_cnt);
      if (ev_st2_edge) begin
        bits_left_q <= BC_W'(NBITS);
        shift_q     <= '0;
      end
      if (ev_bit_sampled) begin
        shift_q    <= {shift_q[NBITS-2:0], line_s};
        last_bit_q <= line_s;
      end
      if (ev_mid_edge) bits_left_q <= bits_left_q - 1'b1;
    end
  end

  AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_START && $past(state_q) == ST_IDLE) |-> $past(idle_cnt) >= IW'(IDLE_TICKS))
    else $error("start hunt entered without full idle"); // R1

  AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_cnt <= AW'(TIMEOUT_TICKS))
    else $error("attempt counter ran past its limit"); // R2

  AST_HALF_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START2 && $past(state_q) == ST_MEASURE) |-> half_q < HW'(HALF_LIMIT))
    else $error("half-bit width latched at or above limit"); // R3

  AST_EDGE_RESTARTS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mid_edge |=> phase_cnt == '0)
    else $error("mid-bit edge did not restart phase timer"); // R6

  AST_BITS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left_q <= BC_W'(NBITS))
    else $error("bit counter out of range"); // R7
endmodule

// File: rtl/ir_result_reg.sv
module ir_result_reg #(
  parameter int SYS_W = 5,
  parameter int CMD_W = 6,
  localparam int NBITS = 1 + SYS_W + CMD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_done,
  input  logic             ev_fault,
  input  logic [NBITS-1:0] word,
  output logic [SYS_W-1:0] sys_addr,
  output logic [CMD_W-1:0] command,
  output logic             toggle,
  output logic             frame_valid,
  output logic             fault
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_addr    <= '0;
      command     <= '0;
      toggle      <= 1'b0;
      frame_valid <= 1'b0;
      fault       <= 1'b0;
    end else begin
      frame_valid <= ev_done;
      fault       <= ev_fault;
      if (ev_fault) begin
        sys_addr <= '1;
        command  <= '1;
      end else if (ev_done) begin
        toggle   <= word[NBITS-1];
        sys_addr <= word[NBITS-2 -: SYS_W];
        command  <= word[CMD_W-1:0];
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid)
    else $error("frame_valid longer than one clock"); // R7

  AST_FAULT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (sys_addr == '1 && command == '1))
    else $error("fields not all ones on fault"); // R8

  AST_FAULT_KEEPS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(toggle))
    else $error("toggle changed on fault"); // R8

  AST_NO_VALID_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && fault))
    else $error("valid and fault together"); // R8
endmodule

// File: rtl/ir_manchester_rx.sv
module ir_manchester_rx #(
  parameter int SYS_W         = 5,
  parameter int CMD_W         = 6,
  parameter int IDLE_TICKS    = 55,
  parameter int HALF_LIMIT    = 17,
  parameter int TIMEOUT_TICKS = 2048,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ir_in,
  output logic [SYS_W-1:0] sys_addr,
  output logic [CMD_W-1:0] command,
  output logic             toggle,
  output logic             frame_valid,
  output logic             fault
);
  localparam int NBITS = 1 + SYS_W + CMD_W;
  localparam int IW    = $clog2(IDLE_TICKS + 1);
  localparam int AW    = $clog2(TIMEOUT_TICKS + 1);
  localparam int PW    = $clog2(3 * HALF_LIMIT + 1);

  logic             line_s;
  logic [IW-1:0]    idle_cnt;
  logic [AW-1:0]    attempt_cnt;
  logic [PW-1:0]    phase_cnt;
  logic             idle_clr, attempt_clr, phase_clr;
  logic             ev_done, ev_fault;
  logic [NBITS-1:0] frame_word;

  ir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(ir_in), .d_out(line_s)
  );

  ir_tick_count #(.W(IW)) u_idle_cnt (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .tick(tick), .count(idle_cnt)
  );

  ir_tick_count #(.W(AW)) u_attempt_cnt (
    .clk(clk), .rst_n(rst_n), .clr(attempt_clr), .tick(tick), .count(attempt_cnt)
  );

  ir_tick_count #(.W(PW)) u_phase_cnt (
    .clk(clk), .rst_n(rst_n), .clr(phase_clr), .tick(tick), .count(phase_cnt)
  );

  ir_frame_fsm #(
    .NBITS(NBITS), .IDLE_TICKS(IDLE_TICKS),
    .HALF_LIMIT(HALF_LIMIT), .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_s(line_s),
    .idle_cnt(idle_cnt), .attempt_cnt(attempt_cnt), .phase_cnt(phase_cnt),
    .idle_clr(idle_clr), .attempt_clr(attempt_clr), .phase_clr(phase_clr),
    .ev_done(ev_done), .ev_fault(ev_fault), .frame_word(frame_word)
  );

  ir_result_reg #(.SYS_W(SYS_W), .CMD_W(CMD_W)) u_result (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_fault(ev_fault),
    .word(frame_word), .sys_addr(sys_addr), .command(command),
    .toggle(toggle), .frame_valid(frame_valid), .fault(fault)
  );
endmodule

// File: tb/tb_ir_manchester_rx.sv
module tb_ir_manchester_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int NB         = 12;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ir_in = 1'b1;
  logic [4:0] sys_addr;
  logic [5:0] command;
  logic toggle, frame_valid, fault;

  int n_checks = 0, n_errors = 0, n_valid = 0, n_fault = 0;
  logic [4:0] cap_sys;
  logic [5:0] cap_cmd;
  logic cap_tog;
  bit valid_prev = 1'b0, valid_wide = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_manchester_rx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ir_in(ir_in),
    .sys_addr(sys_addr), .command(command), .toggle(toggle),
    .frame_valid(frame_valid), .fault(fault)
  );

  initial begin
    forever begin
      repeat (TICK_DIV-1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_valid) begin
        n_valid++;
        cap_sys = sys_addr; cap_cmd = command; cap_tog = toggle;
        if (valid_prev) valid_wide = 1'b1;
      end
      if (fault) n_fault++;
      valid_prev = frame_valid;
    end
  end

  function automatic int exp_ref1(input int h);
    return h + h / 2;
  endfunction

  function automatic int exp_ref2(input int h);
    return h * 2 + h / 2;
  endfunction

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic drive_frame(input int idle, input int h, input int first_low,
                             input int st2_high, input logic [NB-1:0] w, input int stretch);
    logic b;
    hold(1'b1, idle);
    hold(1'b0, first_low);
    hold(1'b1, st2_high);
    hold(1'b0, h);
    for (int i = NB-1; i >= 0; i--) begin
      b = w[i];
      if (i == stretch) begin
        hold(b, 3 * h);
        ir_in = 1'b1;
        return;
      end
      hold(b, h);
      hold(!b, h);
    end
    ir_in = 1'b1;
  endtask

  task automatic run_frame(input string tag, input int idle, input int h, input int first_low,
                           input int st2_high, input logic [NB-1:0] w, input int stretch,
                           input bit expect_ok);
    int v0, f0;
    logic tog0;
    v0 = n_valid; f0 = n_fault; tog0 = toggle;
    drive_frame(idle, h, first_low, st2_high, w, stretch);
    hold(1'b1, 8);
    if (expect_ok) begin
      check_eq(tag, "valid pulses", n_valid, v0 + 1);
      check_eq(tag, "fault pulses", n_fault, f0);
      check_eq(tag, "toggle field", int'(cap_tog), int'(w[11]));
      check_eq(tag, "system field", int'(cap_sys), int'(w[10:6]));
      check_eq(tag, "command field", int'(cap_cmd), int'(w[5:0]));
    end else begin
      check_eq(tag, "fault pulses", n_fault, f0 + 1);
      check_eq(tag, "valid pulses", n_valid, v0);
      check_eq("R8", "system all ones", int'(sys_addr), 31);
      check_eq("R8", "command all ones", int'(command), 63);
      check_eq("R8", "toggle kept", int'(toggle), int'(tog0));
    end
  endtask

  initial begin
    int h, f0, v0;
    logic [NB-1:0] w;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    check_eq("R10", "reset system", int'(sys_addr), 0);
    check_eq("R10", "reset command", int'(command), 0);
    check_eq("R10", "reset toggle", int'(toggle), 0);
    check_eq("R10", "reset valid", int'(frame_valid), 0);
    check_eq("R10", "reset fault", int'(fault), 0);
    rst_n = 1'b1;

    run_frame("R5", 70, 14, 14, 14, 12'b1_10101_011001, -1, 1'b1);
    run_frame("R5", 60, 14, 14, 14, 12'h000, -1, 1'b1);
    run_frame("R5", 60, 14, 14, 14, 12'hFFF, -1, 1'b1);
    run_frame("R3", 60, 15, 15, 15, 12'h5A3, -1, 1'b1);
    run_frame("R3", 60, 12, 19, 12, 12'h3C5, -1, 1'b0);
    run_frame("R11", 60, 13, 13, 13, 12'hA96, -1, 1'b1);
    run_frame("R4", 60, 10, 10, exp_ref1(10) + 3, 12'h123, -1, 1'b0);
    run_frame("R4", 60, 10, 10, exp_ref1(10) - 3, 12'h9E1, -1, 1'b1);
    run_frame("R6", 60, 12, 12, 12, 12'h6B4, 4, 1'b0);
    check_eq("R6", "stretch exceeds edge window", int'(3 * 12 > exp_ref2(12)), 1);

    for (int k = 0; k < 14; k++) begin
      h = 8 + int'($urandom % 8);
      if (k == 0) h = 8;
      if (k == 1) h = 15;
      w = NB'($urandom);
      run_frame("R9", 60 + int'($urandom % 20), h, h, h, w, -1, 1'b1);
    end

    // R1: short low during idle restarts the count; no frame accepted
    v0 = n_valid; f0 = n_fault;
    hold(1'b1, 20);
    hold(1'b0, 2);
    drive_frame(40, 14, 14, 14, 12'h7E7, -1);
    hold(1'b1, 8);
    check_eq("R1", "no valid without idle", n_valid, v0);
    check_eq("R1", "no fault yet", n_fault, f0);
    for (int j = 0; j < 48 && n_fault == f0; j++) hold(1'b1, 50);
    check_eq("R2", "timeout fault after hunt", n_fault, f0 + 1);
    check_eq("R8", "system all ones after timeout", int'(sys_addr), 31);

    run_frame("R11", 60, 14, 14, 14, 12'h4D2, -1, 1'b1);

    // R2: timeout edges measured from the last outcome
    f0 = n_fault;
    hold(1'b1, 1990);
    check_eq("R2", "no fault before limit", n_fault, f0);
    hold(1'b1, 110);
    check_eq("R2", "fault after limit", n_fault, f0 + 1);
    check_eq("R8", "command all ones after timeout", int'(command), 63);

    run_frame("R11", 60, 11, 11, 11, 12'hC3A, -1, 1'b1);
    check_eq("R7", "valid pulse width one clock", int'(valid_wide), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule